// File: doc/BRIEF.md
# Monitor channel handshake controller

This block sits between a processor and a byte-wide monitor channel that carries one slot per frame on a time-division serial link. Both directions of the channel are handled. On receive, a byte is accepted only after the far end has shown the same value in two frames in a row. A pair of copies that disagree is an abort. A run of silent frames after at least one accepted byte marks the end of a message. On transmit, the block tells software when a new byte may be written. It repeats that byte on the line until the far end acknowledges it, then leaves one silent frame before it signals ready again.

Every event raises a status bit and holds its direction in a wait state until software services it. Software clears the status bit first and then touches the data register. A level-sensitive channel reset returns both directions to their initial state and clears every status bit. A frame strobe marks the cycle in which the slot fields are valid on the line side. Status bits are cleared by writing ones to them.

Top module: `mon_chan_ctrl`

## Requirements
- R1: Status bit 2 (receive-ready) is set, and `rd_dat` takes the slot value, when two consecutive frames both carry `rx_vld`=1 with equal `rx_dat`. A single copy sets nothing.
- R2: After an accepted byte, the receiver ignores every frame until `rd_stb` is pulsed. After that read it accepts a new byte only after at least one frame with `rx_vld`=0.
- R3: If receive-ready is still set when the next byte is accepted, the bit shows no new rising edge. If software then clears the bit without reading, later bytes are ignored until `rd_stb` is pulsed.
- R4: Two consecutive active frames with different `rx_dat` set status bit 3 (receive-abort) and leave `rd_dat` unchanged. No byte is accepted while that bit is set.
- R5: `EOM_GAPS` consecutive frames with `rx_vld`=0, after at least one byte accepted since the last end of message or abort, set status bit 4 (end-of-message). No byte is accepted while that bit is set. Silent frames with no accepted byte before them set nothing.
- R6: Status bit 0 (transmit-ready) is set in the cycle after reset ends. A `wr_stb` while the transmitter is idle drives `tx_vld`=1 and `tx_dat`=`wr_dat` from the next cycle. The byte stays on the line until a frame with `rx_ack`=1 at or after its `TX_MIN_REP`-th copy. One silent frame follows, and at the end of that frame transmit-ready is set again.
- R7: Whenever `tx_vld` is 0, `tx_dat` is all ones.
- R8: A frame with `rx_abt`=1 sets status bit 1 (remote-abort) and transmit-ready, and drops the byte being sent. A `wr_stb` while remote-abort is set is discarded, and the transmitter stays idle.
- R9: A one in `sts_clr` clears that status bit. If a set and a clear of the same bit fall in one cycle, the set wins.
- R10: While `chan_rst` is 1, all five status bits read 0, `tx_vld` is 0, and both directions return to their initial state. The receiver needs no read afterwards. Transmit-ready is set in the cycle after `chan_rst` falls.
- R11: A `wr_stb` while a byte is still being sent is discarded, and `tx_dat` keeps the byte in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_rst | input | 1 | Level-sensitive channel reset for both directions |
| frm_stb | input | 1 | One-cycle pulse marking this frame's monitor slot |
| rx_dat | input | DW | Received slot byte |
| rx_vld | input | 1 | Far end's data-present handshake for this frame |
| rx_ack | input | 1 | Far end's acknowledge of the byte we send |
| rx_abt | input | 1 | Far end reports an abort |
| tx_dat | output | DW | Transmitted slot byte, all ones when idle |
| tx_vld | output | 1 | Our data-present handshake |
| rd_stb | input | 1 | Software read of the receive data register |
| rd_dat | output | DW | Receive data register |
| wr_stb | input | 1 | Software write of the transmit data register |
| wr_dat | input | DW | Byte written to the transmit data register |
| sts_clr | input | 5 | Write-one-to-clear mask for the status bits |
| sts | output | 5 | Status: 0 transmit-ready, 1 remote-abort, 2 receive-ready, 3 receive-abort, 4 end-of-message |

## Verification
The collision that matters most is a software clear of receive-ready landing in the same cycle as the frame that validates the next byte. The bench provokes it by reading the data register while leaving the bit set, then driving the second copy of a fresh byte with the clear mask for bit 2 on that same frame strobe. The bit must read 1 afterwards and the register must hold the new byte. A second coincidence is a transmit write offered while a remote abort is still pending; it is judged by `tx_vld` staying low and the line staying all ones.

// File: rtl/mon_chan_pkg.sv
package mon_chan_pkg;
   localparam int NSTS      = 5;
   localparam int S_TXRDY   = 0;
   localparam int S_FARAB   = 1;
   localparam int S_RXRDY   = 2;
   localparam int S_RXABT   = 3;
   localparam int S_RXEOM   = 4;

   typedef enum logic [1:0] {RX_GAP, RX_ONE, RX_SKIP} rx_st_t;
   typedef enum logic [1:0] {TX_INIT, TX_IDLE, TX_SEND, TX_GAP} tx_st_t;
endpackage

// File: rtl/mon_chan_flags.sv
module mon_chan_flags #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold_clr,
   input  logic [N-1:0] set_v,
   input  logic [N-1:0] clr_v,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        b_q <= 1'b0;
         else if (hold_clr) b_q <= 1'b0;
         else               b_q <= set_v[i] | (b_q & ~clr_v[i]);
      end
      assign q[i] = b_q;

      AST_W1C_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(q[i]) |-> $past(clr_v[i] || hold_clr)); // R9
   end

   AST_CHAN_RST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      hold_clr |=> (q == '0)); // R10
endmodule

// File: rtl/mon_chan_rx.sv
module mon_chan_rx
   import mon_chan_pkg::*;
#(
   parameter int DW       = 8,
   parameter int EOM_GAPS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chan_rst,
   input  logic          frm_stb,
   input  logic [DW-1:0] rx_dat,
   input  logic          rx_vld,
   input  logic          rd_stb,
   input  logic          lock_ab,
   input  logic          lock_eom,
   output logic          set_rdy,
   output logic          set_ab,
   output logic          set_eom,
   output logic [DW-1:0] rd_dat
);
   localparam int GW = $clog2(EOM_GAPS + 1);

   rx_st_t        st, st_n;
   logic [DW-1:0] held, held_n, rd_q, rd_n;
   logic [GW-1:0] gcnt, gcnt_n;
   logic          msg, msg_n, wait_rd, wait_n, lock;

   assign lock = wait_rd | lock_ab | lock_eom;

   always_comb begin
      st_n = st; held_n = held; rd_n = rd_q; gcnt_n = gcnt;
      msg_n = msg; wait_n = wait_rd;
      set_rdy = 1'b0; set_ab = 1'b0; set_eom = 1'b0;
      if (rd_stb) wait_n = 1'b0;
      if (frm_stb) begin
         if (lock) begin
            st_n   = RX_SKIP;
            gcnt_n = '0;
         end else if (!rx_vld) begin
            st_n   = RX_GAP;
            gcnt_n = (gcnt == GW'(EOM_GAPS)) ? gcnt : gcnt + GW'(1);
            if (gcnt == GW'(EOM_GAPS - 1) && msg) begin
               set_eom = 1'b1;
               msg_n   = 1'b0;
            end
         end else begin
            gcnt_n = '0;
            case (st)
               RX_GAP: begin
                  st_n   = RX_ONE;
                  held_n = rx_dat;
               end
               RX_ONE: begin
                  st_n = RX_SKIP;
                  if (rx_dat == held) begin
                     set_rdy = 1'b1;
                     rd_n    = rx_dat;
                     wait_n  = 1'b1;
                     msg_n   = 1'b1;
                  end else begin
                     set_ab = 1'b1;
                     msg_n  = 1'b0;
                  end
               end
               default: st_n = RX_SKIP;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= RX_GAP; held <= '0; rd_q <= '0; gcnt <= '0; msg <= 1'b0; wait_rd <= 1'b0;
      end else if (chan_rst) begin
         st <= RX_GAP; gcnt <= '0; msg <= 1'b0; wait_rd <= 1'b0;
      end else begin
         st <= st_n; held <= held_n; rd_q <= rd_n; gcnt <= gcnt_n;
         msg <= msg_n; wait_rd <= wait_n;
      end
   end

   assign rd_dat = rd_q;

   AST_RX_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wait_rd |=> $stable(rd_dat)); // R2
   AST_RX_ABT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      lock_ab |=> $stable(rd_dat)); // R4
endmodule

// File: rtl/mon_chan_tx.sv
module mon_chan_tx
   import mon_chan_pkg::*;
#(
   parameter int DW      = 8,
   parameter int MIN_REP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chan_rst,
   input  logic          frm_stb,
   input  logic          rx_ack,
   input  logic          rx_abt,
   input  logic          wr_stb,
   input  logic [DW-1:0] wr_dat,
   input  logic          rab_set,
   output logic          set_rdy,
   output logic          set_rab,
   output logic [DW-1:0] tx_dat,
   output logic          tx_vld
);
   localparam int CW = $clog2(MIN_REP + 1);

   tx_st_t        st, st_n;
   logic [DW-1:0] byte_q, byte_n;
   logic [CW-1:0] cnt, cnt_n;
   logic          abort;

   assign abort = frm_stb & rx_abt;

   always_comb begin
      st_n = st; byte_n = byte_q; cnt_n = cnt;
      set_rdy = 1'b0; set_rab = 1'b0;
      case (st)
         TX_INIT: begin
            st_n    = TX_IDLE;
            set_rdy = 1'b1;
         end
         TX_IDLE: if (wr_stb && !rab_set) begin
            st_n   = TX_SEND;
            byte_n = wr_dat;
            cnt_n  = '0;
         end
         TX_SEND: if (frm_stb) begin
            if (cnt != CW'(MIN_REP)) cnt_n = cnt + CW'(1);
            if (cnt >= CW'(MIN_REP - 1) && rx_ack) st_n = TX_GAP;
         end
         default: if (frm_stb) begin
            st_n    = TX_IDLE;
            set_rdy = 1'b1;
         end
      endcase
      if (abort) begin
         st_n    = TX_IDLE;
         set_rab = 1'b1;
         set_rdy = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= TX_INIT; byte_q <= '0; cnt <= '0;
      end else if (chan_rst) begin
         st <= TX_INIT; cnt <= '0;
      end else begin
         st <= st_n; byte_q <= byte_n; cnt <= cnt_n;
      end
   end

   assign tx_vld = (st == TX_SEND);
   assign tx_dat = tx_vld ? byte_q : {DW{1'b1}};

   AST_TX_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_vld && $past(tx_vld)) |-> $stable(tx_dat)); // R11
   AST_TX_RAB_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && rab_set && !tx_vld) |=> !tx_vld); // R8
endmodule

// File: rtl/mon_chan_ctrl.sv
module mon_chan_ctrl
   import mon_chan_pkg::*;
#(
   parameter int DW         = 8,
   parameter int TX_MIN_REP = 2,
   parameter int EOM_GAPS   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chan_rst,
   input  logic          frm_stb,
   input  logic [DW-1:0] rx_dat,
   input  logic          rx_vld,
   input  logic          rx_ack,
   input  logic          rx_abt,
   output logic [DW-1:0] tx_dat,
   output logic          tx_vld,
   input  logic          rd_stb,
   output logic [DW-1:0] rd_dat,
   input  logic          wr_stb,
   input  logic [DW-1:0] wr_dat,
   input  logic [4:0]    sts_clr,
   output logic [4:0]    sts
);
   if (DW < 2) begin : g_bad_dw
      $error("mon_chan_ctrl: DW must be 2 or more");
   end
   if (TX_MIN_REP < 2) begin : g_bad_rep
      $error("mon_chan_ctrl: TX_MIN_REP must be 2 or more");
   end
   if (EOM_GAPS < 1) begin : g_bad_gap
      $error("mon_chan_ctrl: EOM_GAPS must be 1 or more");
   end

   logic            rx_rdy_s, rx_ab_s, rx_eom_s, tx_rdy_s, tx_rab_s;
   logic [NSTS-1:0] set_v;

   mon_chan_rx #(.DW(DW), .EOM_GAPS(EOM_GAPS)) u_rx (
      .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .frm_stb(frm_stb),
      .rx_dat(rx_dat), .rx_vld(rx_vld), .rd_stb(rd_stb),
      .lock_ab(sts[S_RXABT]), .lock_eom(sts[S_RXEOM]),
      .set_rdy(rx_rdy_s), .set_ab(rx_ab_s), .set_eom(rx_eom_s), .rd_dat(rd_dat)
   );

   mon_chan_tx #(.DW(DW), .MIN_REP(TX_MIN_REP)) u_tx (
      .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .frm_stb(frm_stb),
      .rx_ack(rx_ack), .rx_abt(rx_abt), .wr_stb(wr_stb), .wr_dat(wr_dat),
      .rab_set(sts[S_FARAB]), .set_rdy(tx_rdy_s), .set_rab(tx_rab_s),
      .tx_dat(tx_dat), .tx_vld(tx_vld)
   );

   always_comb begin
      set_v          = '0;
      set_v[S_TXRDY] = tx_rdy_s;
      set_v[S_FARAB] = tx_rab_s;
      set_v[S_RXRDY] = rx_rdy_s;
      set_v[S_RXABT] = rx_ab_s;
      set_v[S_RXEOM] = rx_eom_s;
   end

   mon_chan_flags #(.N(NSTS)) u_flags (
      .clk(clk), .rst_n(rst_n), .hold_clr(chan_rst),
      .set_v(set_v), .clr_v(sts_clr), .q(sts)
   );

   AST_RXRDY_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[S_RXRDY]) |-> $past(frm_stb && rx_vld)); // R1
   AST_EOM_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[S_RXEOM]) |-> $past(frm_stb && !rx_vld)); // R5
endmodule

// File: tb/tb_mon_chan_ctrl.sv
`timescale 1ns/1ps
module tb_mon_chan_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0, chan_rst = 1'b0, frm_stb = 1'b0;
   logic [7:0] rx_dat = 8'hFF, wr_dat = 8'h00;
   logic       rx_vld = 1'b0, rx_ack = 1'b0, rx_abt = 1'b0;
   logic       rd_stb = 1'b0, wr_stb = 1'b0;
   logic [4:0] sts_clr = 5'b0;
   logic [7:0] tx_dat, rd_dat;
   logic       tx_vld;
   logic [4:0] sts;
   int         n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   mon_chan_ctrl dut (
      .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .frm_stb(frm_stb),
      .rx_dat(rx_dat), .rx_vld(rx_vld), .rx_ack(rx_ack), .rx_abt(rx_abt),
      .tx_dat(tx_dat), .tx_vld(tx_vld), .rd_stb(rd_stb), .rd_dat(rd_dat),
      .wr_stb(wr_stb), .wr_dat(wr_dat), .sts_clr(sts_clr), .sts(sts)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic frm(input logic [7:0] d, input logic v, input logic a,
                      input logic b, input logic [4:0] c);
      @(negedge clk);
      rx_dat = d; rx_vld = v; rx_ack = a; rx_abt = b; sts_clr = c; frm_stb = 1'b1;
      @(negedge clk);
      frm_stb = 1'b0; sts_clr = 5'b0; rx_vld = 1'b0; rx_ack = 1'b0; rx_abt = 1'b0; rx_dat = 8'hFF;
      @(negedge clk);
   endtask

   task automatic gap();
      frm(8'hFF, 1'b0, 1'b0, 1'b0, 5'b0);
   endtask

   task automatic byte2(input logic [7:0] d);
      frm(d, 1'b1, 1'b0, 1'b0, 5'b0);
      frm(d, 1'b1, 1'b0, 1'b0, 5'b0);
   endtask

   task automatic clr(input logic [4:0] m);
      @(negedge clk); sts_clr = m;
      @(negedge clk); sts_clr = 5'b0;
   endtask

   task automatic rd();
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); wr_stb = 1'b1; wr_dat = d;
      @(negedge clk); wr_stb = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 reset status", sts, 5'b00001);
      chk("R7 idle vld", tx_vld, 0);
      chk("R7 idle ones", tx_dat, 8'hFF);
      clr(5'b00001);
      chk("R9 clear", sts, 5'b0);

      // R1: sweep of byte values, each sent as two copies
      for (int i = 0; i < 16; i++) begin
         logic [7:0] v;
         v = 8'(i * 17) ^ 8'h5A;
         frm(v, 1'b1, 1'b0, 1'b0, 5'b0);
         chk("R1 one copy", sts[2], 0);
         frm(v, 1'b1, 1'b0, 1'b0, 5'b0);
         chk("R1 ready", sts[2], 1);
         chk("R1 data", rd_dat, v);
         clr(5'b00100);
         rd();
         gap();
      end

      // R2: locked until read, then needs a silent frame
      byte2(8'h3C);
      chk("R2 first", rd_dat, 8'h3C);
      clr(5'b00100);
      gap();
      byte2(8'hC3);
      chk("R2 locked data", rd_dat, 8'h3C);
      chk("R2 locked flag", sts[2], 0);
      chk("R2 no eom while locked", sts[4], 0);
      rd();
      byte2(8'hC3);
      chk("R2 needs gap", rd_dat, 8'h3C);
      gap();
      byte2(8'hC3);
      chk("R2 after gap", rd_dat, 8'hC3);
      chk("R2 after gap flag", sts[2], 1);

      // R3: bit still set at next byte; clear without read keeps lock
      rd();
      gap();
      byte2(8'h77);
      chk("R3 data", rd_dat, 8'h77);
      chk("R3 flag held", sts[2], 1);
      clr(5'b00100);
      gap();
      byte2(8'h88);
      chk("R3 locked data", rd_dat, 8'h77);
      chk("R3 locked flag", sts[2], 0);
      rd();
      gap();
      byte2(8'h88);
      chk("R3 released", rd_dat, 8'h88);
      clr(5'b00100);
      rd();

      // R4: mismatch abort and lock
      gap();
      frm(8'h12, 1'b1, 1'b0, 1'b0, 5'b0);
      frm(8'h13, 1'b1, 1'b0, 1'b0, 5'b0);
      chk("R4 abort flag", sts[3], 1);
      chk("R4 data kept", rd_dat, 8'h88);
      gap();
      byte2(8'h66);
      chk("R4 locked", rd_dat, 8'h88);
      chk("R4 locked flag", sts[2], 0);
      clr(5'b01000);
      chk("R4 cleared", sts[3], 0);
      gap();
      byte2(8'h66);
      chk("R4 resumed", rd_dat, 8'h66);
      clr(5'b00100);
      rd();
      for (int k = 0; k < 8; k++) begin
         logic [7:0] v;
         v = 8'hA0 + 8'(k);
         gap();
         frm(v, 1'b1, 1'b0, 1'b0, 5'b0);
         frm(v ^ (8'h01 << k), 1'b1, 1'b0, 1'b0, 5'b0);
         chk("R4 sweep flag", sts[3], 1);
         chk("R4 sweep data", rd_dat, 8'h66);
         clr(5'b01000);
      end

      // R5: end of message
      gap();
      byte2(8'h21);
      clr(5'b00100);
      rd();
      gap();
      chk("R5 one gap", sts[4], 0);
      gap();
      chk("R5 eom", sts[4], 1);
      gap();
      byte2(8'h31);
      chk("R5 locked", rd_dat, 8'h21);
      clr(5'b10000);
      gap(); gap(); gap();
      chk("R5 no message no eom", sts[4], 0);
      byte2(8'h31);
      chk("R5 resumed", rd_dat, 8'h31);
      clr(5'b00100);   // left unread: receiver locked during transmit tests

      // R6/R7: transmit with repeat and acknowledge
      wr(8'hA5);
      chk("R6 vld", tx_vld, 1);
      chk("R6 data", tx_dat, 8'hA5);
      frm(8'hFF, 1'b0, 1'b1, 1'b0, 5'b0);
      chk("R6 early ack ignored", tx_vld, 1);
      frm(8'hFF, 1'b0, 1'b0, 1'b0, 5'b0);
      chk("R6 waits ack", tx_vld, 1);
      frm(8'hFF, 1'b0, 1'b1, 1'b0, 5'b0);
      chk("R7 gap vld", tx_vld, 0);
      chk("R7 gap ones", tx_dat, 8'hFF);
      chk("R6 not ready in gap", sts[0], 0);
      gap();
      chk("R6 ready again", sts[0], 1);

      // R11: write while busy
      clr(5'b00001);
      wr(8'h5A);
      wr(8'hE7);
      chk("R11 kept", tx_dat, 8'h5A);
      frm(8'hFF, 1'b0, 1'b1, 1'b0, 5'b0);
      frm(8'hFF, 1'b0, 1'b1, 1'b0, 5'b0);
      chk("R11 done", tx_vld, 0);
      gap();
      chk("R11 ready", sts[0], 1);

      // R8: remote abort
      clr(5'b00001);
      wr(8'hC4);
      frm(8'hFF, 1'b0, 1'b0, 1'b1, 5'b0);
      chk("R8 flags", sts[1:0], 2'b11);
      chk("R8 dropped", tx_vld, 0);
      clr(5'b00001);
      wr(8'h99);
      chk("R8 discard vld", tx_vld, 0);
      chk("R8 discard ones", tx_dat, 8'hFF);
      gap();
      chk("R8 still idle", tx_vld, 0);
      clr(5'b00010);
      wr(8'h99);
      chk("R8 accepted", tx_dat, 8'h99);
      frm(8'hFF, 1'b0, 1'b1, 1'b0, 5'b0);
      frm(8'hFF, 1'b0, 1'b1, 1'b0, 5'b0);
      gap();
      clr(5'b00001);

      // R9: set and clear in the same cycle
      rd();
      gap();
      byte2(8'h42);
      rd();
      gap();
      frm(8'h43, 1'b1, 1'b0, 1'b0, 5'b0);
      frm(8'h43, 1'b1, 1'b0, 1'b0, 5'b00100);
      chk("R9 set wins", sts[2], 1);
      chk("R9 data", rd_dat, 8'h43);
      clr(5'b00100);
      chk("R9 cleared", sts, 5'b0);

      // R10: channel reset with traffic in both directions
      frm(8'hFF, 1'b0, 1'b0, 1'b1, 5'b0);
      clr(5'b00010);
      wr(8'hB2);
      chk("R10 pre send", tx_vld, 1);
      @(negedge clk); chan_rst = 1'b1;
      @(negedge clk);
      chk("R10 status", sts, 5'b0);
      chk("R10 tx", tx_vld, 0);
      frm(8'h55, 1'b1, 1'b0, 1'b0, 5'b0);
      chk("R10 held", sts, 5'b0);
      @(negedge clk); chan_rst = 1'b0;
      @(negedge clk);
      chk("R10 ready after", sts, 5'b00001);
      byte2(8'h55);
      chk("R10 rx rearmed", rd_dat, 8'h55);
      chk("R10 rx flag", sts[2], 1);

      summary();
      $finish;
   end
endmodule